// File: doc/BRIEF.md
# Shadowed Timer with Compare PWM

A general-purpose counter with a period limit and a compare threshold. Both values are double-buffered. Software writes a shadow copy, and the value the counter actually uses is taken from that copy only on selected counter events. A prescaler supplies a one-cycle enable (`tick`), and the count can advance only on enabled cycles. There are four counting modes: hold, up with wrap, up/down triangle, and directional. In directional mode a synchronised external pin steers the count.

A compare unit watches the count. On each match it toggles a PWM waveform, and a polarity input selects an active-high or active-low pin. Three sticky event flags are raised by the counter and the compare unit: count at zero, count at period, and count at compare. Writing a one to a flag's clear bit clears it.

Top module: `shadow_timer_pwm`

## Requirements
- R1: A period write lands in a shadow register. The period in use takes the shadow's contents only on an underflow event. A write made on the same edge as an underflow waits for the next underflow.
- R2: With `count_mode`=2'b01 (up), each tick increments the count. When the count is at or above the period in use, the tick sets it to 0 instead.
- R3: With `count_mode`=2'b10 (up/down), the count rises to the period and falls back to 0. No value is repeated at either turn, so one full cycle takes 2×period ticks.
- R4: With `count_mode`=2'b11 (directional), a high synchronised direction makes the count rise and hold at the period. A low direction makes it fall and hold at 0.
- R5: `dir_in` passes through two flip-flops before the counter uses it. The two clock edges after a change still count with the old level, and the third edge uses the new one.
- R6: With `count_mode`=2'b00 (hold), or with `tick` low, the count does not change and no event is raised.
- R7: With `cmp_reload_mode` 2'b00, or the reserved code 2'b11, the compare value in use takes its shadow only on underflow.
- R8: With `cmp_reload_mode`=2'b01, the compare value in use takes its shadow on underflow or on period match.
- R9: With `cmp_reload_mode`=2'b10, a compare write loads the shadow and the compare value in use on the same edge. Counter events do not reload it.
- R10: The internal waveform resets to 0 and toggles on every compare event. `pwm_out` equals the waveform when `pwm_active_high`=1 and its inverse when `pwm_active_high`=0.
- R11: Events are taken from the count held at a running tick (a tick in any mode except hold). Underflow is count==0, period match is count==period in use, and compare is count==compare in use. They set `flags` bit 0, bit 1 and bit 2 respectively.
- R12: Flags are sticky. A one in `flag_clr` bit i clears flag i. An event on the same edge as the clear keeps the flag set.
- R13: After reset the count is 0, all flags are 0, the shadows and the values in use are 0, and the waveform is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Count enable from the prescaler |
| dir_in | input | 1 | External direction level for directional mode |
| count_mode | input | 2 | 00 hold, 01 up, 10 up/down, 11 directional |
| cmp_reload_mode | input | 2 | 00 underflow, 01 underflow or period, 10 on write, 11 as 00 |
| pwm_active_high | input | 1 | 1: pin equals waveform, 0: pin inverted |
| prd_wr | input | 1 | Write strobe for the period shadow |
| prd_wdata | input | W | Period write data |
| cmp_wr | input | 1 | Write strobe for the compare shadow |
| cmp_wdata | input | W | Compare write data |
| flag_clr | input | 3 | Write-one-to-clear for the flags |
| count | output | W | Current count |
| pwm_out | output | 1 | PWM pin |
| flags | output | 3 | Bit 0 underflow, bit 1 period match, bit 2 compare |

## Verification
Two pairs of functions can fall in the same cycle.

The first pair is a flag clear and a new event for that flag. The bench writes the underflow clear bit on the very tick where the count sits at 0. It passes only if the flag reads set afterwards, and a plain clear on the next tick then empties it.

The second pair is a shadow write and a reload. The bench writes the compare shadow on the underflow tick of an up/down run. The old value must still be the one in use until the next reload event chosen by the mode, and the edge at which the waveform next toggles shows which value was taken.

// File: rtl/stp_pkg.sv
package stp_pkg;

   typedef enum logic [1:0] {
      CM_HOLD = 2'b00,
      CM_UP   = 2'b01,
      CM_UPDN = 2'b10,
      CM_DIR  = 2'b11
   } cnt_mode_e;

   typedef enum logic [1:0] {
      RL_ZERO     = 2'b00,
      RL_ZERO_PRD = 2'b01,
      RL_WRITE    = 2'b10,
      RL_RSVD     = 2'b11
   } reload_e;

   localparam int FLAG_UF = 0;
   localparam int FLAG_PM = 1;
   localparam int FLAG_CM = 2;
   localparam int NFLAGS  = 3;

endpackage

// File: rtl/stp_dir_sync.sv
module stp_dir_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   generate
      if (STAGES < 1) begin : g_bad
         $error("stp_dir_sync: STAGES must be at least 1");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   generate
      if (STAGES == 1) begin : g_one
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= d_i;
         end
      end else begin : g_many
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[STAGES-2:0], d_i};
         end
      end
   endgenerate

   assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/stp_shadow_reg.sv
module stp_shadow_reg #(
   parameter int W         = 16,
   parameter bit ALLOW_IMM = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic [W-1:0] wr_data,
   input  logic         reload,
   input  logic         imm,
   output logic [W-1:0] shadow_q,
   output logic [W-1:0] active_q
);
   generate
      if (W < 1) begin : g_bad
         $error("stp_shadow_reg: W must be positive");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     shadow_q <= '0;
      else if (wr_en) shadow_q <= wr_data;
   end

   logic imm_load;

   generate
      if (ALLOW_IMM) begin : g_imm
         assign imm_load = imm & wr_en;
      end else begin : g_noimm
         logic unused_imm;
         assign unused_imm = imm;
         assign imm_load   = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        active_q <= '0;
      else if (imm_load) active_q <= wr_data;
      else if (reload)   active_q <= shadow_q;
   end

   // R1 and R7/R8: a reload takes the shadow's contents from before the edge
   a_r1_reload_takes_shadow: assert property (@(posedge clk) disable iff (!rst_n)
      (reload && !imm_load) |=> (active_q == $past(shadow_q)));

   // R9: an immediate write reaches the active copy on its own edge
   a_r9_immediate_write: assert property (@(posedge clk) disable iff (!rst_n)
      imm_load |=> (active_q == $past(wr_data)));

   a_r1_hold_without_event: assert property (@(posedge clk) disable iff (!rst_n)
      (!reload && !imm_load) |=> $stable(active_q));

endmodule

// File: rtl/stp_counter.sv
module stp_counter
   import stp_pkg::*;
#(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  cnt_mode_e    mode,
   input  logic         dir_up,
   input  logic [W-1:0] prd,
   output logic [W-1:0] cnt_q,
   output logic         run_o,
   output logic         evt_uf_o,
   output logic         evt_pm_o
);
   localparam logic [W-1:0] ONE = W'(1);

   logic [W-1:0] cnt_d;
   logic         up_q, up_d;

   always_comb begin
      cnt_d = cnt_q;
      up_d  = up_q;
      if (tick) begin
         unique case (mode)
            CM_UP: begin
               up_d  = 1'b1;
               cnt_d = (cnt_q >= prd) ? '0 : cnt_q + ONE;
            end
            CM_UPDN: begin
               if (up_q) begin
                  if (cnt_q >= prd) begin
                     up_d  = 1'b0;
                     cnt_d = (cnt_q == '0) ? '0 : cnt_q - ONE;
                  end else begin
                     cnt_d = cnt_q + ONE;
                  end
               end else begin
                  if (cnt_q == '0) begin
                     up_d  = 1'b1;
                     cnt_d = (prd == '0) ? '0 : ONE;
                  end else begin
                     cnt_d = cnt_q - ONE;
                  end
               end
            end
            CM_DIR: begin
               up_d = 1'b1;
               if (dir_up) cnt_d = (cnt_q >= prd) ? cnt_q : cnt_q + ONE;
               else        cnt_d = (cnt_q == '0) ? cnt_q : cnt_q - ONE;
            end
            default: begin
               cnt_d = cnt_q;
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         up_q  <= 1'b1;
      end else begin
         cnt_q <= cnt_d;
         up_q  <= up_d;
      end
   end

   assign run_o    = tick & (mode != CM_HOLD);
   assign evt_uf_o = run_o & (cnt_q == '0);
   assign evt_pm_o = run_o & (cnt_q == prd);

   a_r2_up_wraps_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && mode == CM_UP && cnt_q >= prd) |=> (cnt_q == '0));

   a_r3_updown_single_step: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && mode == CM_UPDN && prd != '0 && cnt_q <= prd)
      |=> ((cnt_q == $past(cnt_q) + ONE) || (cnt_q == $past(cnt_q) - ONE)));

   a_r4_dir_holds_at_period: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && mode == CM_DIR && dir_up && cnt_q == prd) |=> (cnt_q == $past(cnt_q)));

   a_r4_dir_holds_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && mode == CM_DIR && !dir_up && cnt_q == '0) |=> (cnt_q == '0));

   a_r6_idle_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick || mode == CM_HOLD) |=> $stable(cnt_q));

endmodule

// File: rtl/stp_cmp_out.sv
module stp_cmp_out
   import stp_pkg::*;
#(
   parameter int W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic [W-1:0]      cnt,
   input  logic [W-1:0]      cmp,
   input  logic              evt_uf,
   input  logic              evt_pm,
   input  logic              active_high,
   input  logic [NFLAGS-1:0] clr,
   output logic              evt_cm_o,
   output logic              pwm_o,
   output logic [NFLAGS-1:0] flags_q
);
   logic              wave_q;
   logic [NFLAGS-1:0] set_v;

   assign evt_cm_o = run & (cnt == cmp);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        wave_q <= 1'b0;
      else if (evt_cm_o) wave_q <= ~wave_q;
   end

   assign pwm_o = active_high ? wave_q : ~wave_q;

   always_comb begin
      set_v          = '0;
      set_v[FLAG_UF] = evt_uf;
      set_v[FLAG_PM] = evt_pm;
      set_v[FLAG_CM] = evt_cm_o;
   end

   generate
      for (genvar i = 0; i < NFLAGS; i++) begin : g_flag
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) flags_q[i] <= 1'b0;
            else        flags_q[i] <= set_v[i] | (flags_q[i] & ~clr[i]);
         end

         a_r12_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (flags_q[i] && !clr[i]) |=> flags_q[i]);

         a_r12_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
            set_v[i] |=> flags_q[i]);
      end
   endgenerate

   a_r10_toggle_on_match: assert property (@(posedge clk) disable iff (!rst_n)
      evt_cm_o |=> (wave_q != $past(wave_q)));

   a_r10_steady_without_match: assert property (@(posedge clk) disable iff (!rst_n)
      !evt_cm_o |=> $stable(wave_q));

endmodule

// File: rtl/shadow_timer_pwm.sv
module shadow_timer_pwm
   import stp_pkg::*;
#(
   parameter int W           = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic         dir_in,
   input  logic [1:0]   count_mode,
   input  logic [1:0]   cmp_reload_mode,
   input  logic         pwm_active_high,
   input  logic         prd_wr,
   input  logic [W-1:0] prd_wdata,
   input  logic         cmp_wr,
   input  logic [W-1:0] cmp_wdata,
   input  logic [2:0]   flag_clr,
   output logic [W-1:0] count,
   output logic         pwm_out,
   output logic [2:0]   flags
);
   generate
      if (W < 2 || W > 32) begin : g_bad_w
         $error("shadow_timer_pwm: W must lie in 2..32");
      end
      if (SYNC_STAGES != 2) begin : g_bad_sync
         $error("shadow_timer_pwm: direction latency is specified for 2 stages");
      end
   endgenerate

   cnt_mode_e    mode;
   reload_e      rl_mode;
   logic         dir_s;
   logic [W-1:0] prd_act, prd_shadow;
   logic [W-1:0] cmp_act, cmp_shadow;
   logic         run, evt_uf, evt_pm, evt_cm;
   logic         cmp_reload, cmp_imm;

   assign mode    = cnt_mode_e'(count_mode);
   assign rl_mode = reload_e'(cmp_reload_mode);

   stp_dir_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (dir_in),
      .q_o   (dir_s)
   );

   stp_counter #(.W(W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .mode     (mode),
      .dir_up   (dir_s),
      .prd      (prd_act),
      .cnt_q    (count),
      .run_o    (run),
      .evt_uf_o (evt_uf),
      .evt_pm_o (evt_pm)
   );

   stp_shadow_reg #(.W(W), .ALLOW_IMM(1'b0)) u_prd (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (prd_wr),
      .wr_data  (prd_wdata),
      .reload   (evt_uf),
      .imm      (1'b0),
      .shadow_q (prd_shadow),
      .active_q (prd_act)
   );

   always_comb begin
      cmp_imm    = 1'b0;
      cmp_reload = 1'b0;
      unique case (rl_mode)
         RL_ZERO_PRD: cmp_reload = evt_uf | evt_pm;
         RL_WRITE:    cmp_imm    = 1'b1;
         default:     cmp_reload = evt_uf;
      endcase
   end

   stp_shadow_reg #(.W(W), .ALLOW_IMM(1'b1)) u_cmp (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (cmp_wr),
      .wr_data  (cmp_wdata),
      .reload   (cmp_reload),
      .imm      (cmp_imm),
      .shadow_q (cmp_shadow),
      .active_q (cmp_act)
   );

   stp_cmp_out #(.W(W)) u_out (
      .clk         (clk),
      .rst_n       (rst_n),
      .run         (run),
      .cnt         (count),
      .cmp         (cmp_act),
      .evt_uf      (evt_uf),
      .evt_pm      (evt_pm),
      .active_high (pwm_active_high),
      .clr         (flag_clr),
      .evt_cm_o    (evt_cm),
      .pwm_o       (pwm_out),
      .flags_q     (flags)
   );

   // R11: events only on running ticks
   a_r11_no_event_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> !(evt_uf || evt_pm || evt_cm));

   // R1: the period in use changes only after an underflow
   a_r1_period_changes_on_underflow: assert property (@(posedge clk) disable iff (!rst_n)
      !evt_uf |=> $stable(prd_act));

   // R8: in mode 01 a period match refreshes the compare in use
   a_r8_reload_at_period: assert property (@(posedge clk) disable iff (!rst_n)
      (rl_mode == RL_ZERO_PRD && evt_pm && !cmp_wr) |=> (cmp_act == $past(cmp_shadow)));

endmodule

// File: tb/shadow_timer_pwm_test.sv
module shadow_timer_pwm_test;
   localparam int W = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         tick = 1'b0;
   logic         dir_in = 1'b0;
   logic [1:0]   count_mode = 2'b00;
   logic [1:0]   cmp_reload_mode = 2'b00;
   logic         pwm_active_high = 1'b1;
   logic         prd_wr = 1'b0;
   logic [W-1:0] prd_wdata = '0;
   logic         cmp_wr = 1'b0;
   logic [W-1:0] cmp_wdata = '0;
   logic [2:0]   flag_clr = '0;
   logic [W-1:0] count;
   logic         pwm_out;
   logic [2:0]   flags;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   shadow_timer_pwm #(.W(W)) uut (
      .clk             (clk),
      .rst_n           (rst_n),
      .tick            (tick),
      .dir_in          (dir_in),
      .count_mode      (count_mode),
      .cmp_reload_mode (cmp_reload_mode),
      .pwm_active_high (pwm_active_high),
      .prd_wr          (prd_wr),
      .prd_wdata       (prd_wdata),
      .cmp_wr          (cmp_wr),
      .cmp_wdata       (cmp_wdata),
      .flag_clr        (flag_clr),
      .count           (count),
      .pwm_out         (pwm_out),
      .flags           (flags)
   );

   task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic prime(input logic [W-1:0] p, input logic [W-1:0] c, input logic dv);
      rst_n = 1'b0; tick = 1'b0; count_mode = 2'b00; cmp_reload_mode = 2'b10;
      prd_wr = 1'b0; cmp_wr = 1'b0; flag_clr = '0; dir_in = dv;
      step(); step();
      rst_n = 1'b1;
      prd_wr = 1'b1; prd_wdata = p; cmp_wr = 1'b1; cmp_wdata = c;
      step();
      prd_wr = 1'b0; cmp_wr = 1'b0; count_mode = 2'b01; tick = 1'b1;
      step();
      tick = 1'b0; flag_clr = 3'b111;
      step();
      flag_clr = '0;
   endtask

   task automatic t_reset();
      pwm_active_high = 1'b1;
      rst_n = 1'b0; step();
      chk("R13 count", count, 0);
      chk("R13 flags", flags, 0);
      chk("R13 pwm high", pwm_out, 0);
      pwm_active_high = 1'b0; #1;
      chk("R10 R13 pwm low", pwm_out, 1);
      pwm_active_high = 1'b1;
   endtask

   task automatic t_up_reload();
      prime(3, 1, 1'b0);
      cmp_reload_mode = 2'b00; count_mode = 2'b01; tick = 1'b1;
      step(); chk("R2 count 1", count, 1); chk("R11 underflow flag", flags, 3'b001);
      step(); chk("R2 count 2", count, 2); chk("R10 toggle", pwm_out, 1);
      chk("R12 sticky R11 compare", flags, 3'b101);
      cmp_wr = 1'b1; cmp_wdata = 2;
      step(); cmp_wr = 1'b0; chk("R2 count 3", count, 3);
      step(); chk("R2 wrap", count, 0); chk("R11 period flag", flags, 3'b111);
      step(); chk("R2 count 1b", count, 1);
      step(); chk("R7 reloaded at underflow", pwm_out, 1);
      step(); chk("R7 R10 match new compare", pwm_out, 0);
   endtask

   task automatic t_prd_defer();
      prime(3, 1, 1'b0);
      cmp_reload_mode = 2'b00; count_mode = 2'b01; tick = 1'b1;
      step();
      prd_wr = 1'b1; prd_wdata = 5;
      step(); prd_wr = 1'b0;
      step(); step(); chk("R1 old period kept", count, 0);
      step(); step(); step(); step(); step(); chk("R1 new period peak", count, 5);
      step(); chk("R1 new period wrap", count, 0);
   endtask

   task automatic t_updown(input logic [1:0] rl, input logic e5_pwm, input string rq);
      logic [W-1:0] seq [7] = '{1, 2, 3, 2, 1, 0, 1};
      prime(3, 1, 1'b0);
      cmp_reload_mode = rl; count_mode = 2'b10; tick = 1'b1;
      cmp_wr = 1'b1; cmp_wdata = 2;
      for (int k = 0; k < 7; k++) begin
         step();
         cmp_wr = 1'b0;
         chk("R3 triangle", count, seq[k]);
         if (k == 1) chk(rq, pwm_out, 1);
         if (k == 3) chk("R11 period in updown", flags[1], 1);
         if (k == 4) chk(rq, pwm_out, e5_pwm);
      end
   endtask

   task automatic t_imm();
      prime(3, 1, 1'b0);
      cmp_reload_mode = 2'b10; count_mode = 2'b01; tick = 1'b1;
      step();
      cmp_wr = 1'b1; cmp_wdata = 3;
      step(); cmp_wr = 1'b0; chk("R9 old match", pwm_out, 1);
      step(); chk("R9 no match at 2", pwm_out, 1);
      step(); chk("R9 new compare used", pwm_out, 0);
   endtask

   task automatic t_dir();
      prime(3, 2, 1'b1);
      cmp_reload_mode = 2'b00; count_mode = 2'b11; tick = 1'b1;
      step(); step(); step(); chk("R4 rise to period", count, 3);
      step(); chk("R4 hold at period", count, 3);
      dir_in = 1'b0;
      step(); chk("R5 first edge old level", count, 3);
      step(); chk("R5 second edge old level", count, 3);
      step(); chk("R5 third edge new level", count, 2);
      step(); step(); step(); chk("R4 hold at zero", count, 0);
      chk("R11 underflow in dir", flags[0], 1);
   endtask

   task automatic t_hold();
      prime(3, 1, 1'b0);
      cmp_reload_mode = 2'b00; count_mode = 2'b01; tick = 1'b1;
      step(); step();
      tick = 1'b0; flag_clr = 3'b111; step(); flag_clr = '0;
      step(); step(); step();
      chk("R6 no tick count", count, 2); chk("R6 no tick flags", flags, 0);
      count_mode = 2'b00; tick = 1'b1;
      step(); step(); step();
      chk("R6 hold count", count, 2); chk("R6 hold flags", flags, 0);
      chk("R6 hold pwm", pwm_out, 1);
   endtask

   task automatic t_polarity();
      pwm_active_high = 1'b0;
      prime(3, 1, 1'b0);
      chk("R10 low idle", pwm_out, 1);
      cmp_reload_mode = 2'b00; count_mode = 2'b01; tick = 1'b1;
      step(); step(); chk("R10 low active", pwm_out, 0);
      pwm_active_high = 1'b1;
   endtask

   task automatic t_flags();
      prime(3, 1, 1'b0);
      cmp_reload_mode = 2'b00; count_mode = 2'b01; tick = 1'b1;
      flag_clr = 3'b001;
      step(); chk("R12 set beats clear", flags, 3'b001);
      step(); chk("R12 clear one flag", flags, 3'b100);
      tick = 1'b0; flag_clr = 3'b100;
      step(); flag_clr = '0; chk("R12 clear compare", flags, 3'b000);
   endtask

   initial begin
      t_reset();
      t_up_reload();
      t_prd_defer();
      t_updown(2'b01, 1'b0, "R8 period reload");
      t_updown(2'b11, 1'b1, "R7 reserved as underflow");
      t_imm();
      t_dir();
      t_hold();
      t_polarity();
      t_flags();
      if (!finished) begin
         finished = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      #(8 * 20000);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         failures++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule